// File: doc/BRIEF.md
# Two-Wire Bus Slave Front End with Busy-Poll Refusal

This block is the serial front end of a register-controlled device on a two-wire bus. A system clock oversamples the clock line and the data line. Each line goes through a two-flop synchroniser and a majority filter. The block then finds start and stop conditions and shifts bytes in most significant bit first. The first byte of a transfer is the device address: a fixed 4-bit type code followed by four bits that come from strap pins. The second byte is a command byte and goes to a command executor. Any further bytes are either write data for the executor or read data that the block sends back to the master.

The data line is open-drain. The block has one output, an enable that pulls the line low, and never drives it high. A nonvolatile write engine can raise a busy input. While busy is high, the block refuses to acknowledge its own address. A master can therefore send the address over and over, and the first acknowledge it gets tells it that the write has finished.

Top module: `twp_slave_top`

## Requirements
- R1: After reset, the block ignores the bus until it sees a start condition (data falls while clock is high). Bytes clocked before any start get no acknowledge and produce no output pulse.
- R2: The pull-low enable `sda_oe_o` (1 = pull data low) changes only while the clock line is low.
- R3: The address byte is matched on all eight bits. Bits 7..4 must equal 0101 and bits 3..0 must equal `pin_addr_i`. On a match the block pulls data low during the ninth clock.
- R4: If the address does not match, the block gives no acknowledge and ignores every following byte until the next start.
- R5: If `nv_busy_i` is high when the last address bit is sampled, the address gets no acknowledge. Once `nv_busy_i` is low, the same address is acknowledged.
- R6: The byte after an acknowledged address is the command byte. It is acknowledged and presented on `rx_byte_o` with a one-cycle `cmd_valid_o` pulse.
- R7: When `rd_mode_i` is low at the end of the command acknowledge, every following byte is acknowledged and presented on `rx_byte_o` with a one-cycle `wr_valid_o` pulse.
- R8: When `rd_mode_i` is high at the end of the command acknowledge, `rd_data_i` is sent most significant bit first. Each bit changes only after a clock fall.
- R9: After a read byte, a master acknowledge (data low on the ninth clock) reloads `rd_data_i` and sends it as the next byte. A master non-acknowledge releases data, and the block then ignores the bus until the next start.
- R10: A start condition in the middle of a byte abandons the transfer and begins a new address reception.
- R11: A stop condition (data rises while clock is high) that ends a transfer whose address was acknowledged gives one `xfer_end_o` pulse. The pulses `cmd_valid_o`, `wr_valid_o` and `xfer_end_o` never occur in the same cycle.
- R12: A high pulse on the clock line lasting at most FILT_LEN/2 system clocks (1 clock by default) is filtered out and does not shift a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| pin_addr_i | input | 4 | Strap pins forming the low address bits |
| nv_busy_i | input | 1 | High while a nonvolatile write is running |
| rd_mode_i | input | 1 | Selects read data for the bytes after the command |
| rd_data_i | input | 8 | Byte to send to the master |
| cmd_valid_o | output | 1 | One-cycle pulse: command byte on rx_byte_o |
| wr_valid_o | output | 1 | One-cycle pulse: write data byte on rx_byte_o |
| rx_byte_o | output | 8 | Last byte received after the address |
| xfer_end_o | output | 1 | One-cycle pulse at the stop of an addressed transfer |

## Verification
Some rules are checked by assertions on every cycle. The pull-low enable never moves while the filtered clock is high. A filter output flips only toward its newest sample. A busy address byte never selects the device. Output data does not move on a clock rise. At most one handoff pulse occurs per cycle, and idle means released. Other behaviour can only be shown by the bench's scenarios, because it needs whole bus sequences: the all-bit address compare, the refusal while busy and acknowledge afterwards, ignoring bytes after a mismatch or a master non-acknowledge, restart in the middle of a byte, read data order with reload, and rejection of a one-cycle clock glitch.

// File: rtl/twp_pkg.sv
package twp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } twp_state_e;

    typedef enum logic [1:0] {
        K_ADDR,
        K_CMD,
        K_DATA
    } twp_kind_e;
endpackage

// File: rtl/twp_line_filter.sv
module twp_line_filter #(
    parameter int   FILT_LEN = 3,
    parameter logic RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic [1:0]          sync;
        logic [FILT_LEN-1:0] win;
        logic                lvl;
    } flt_t;

    flt_t q, d;
    logic [CW-1:0] ones;

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], raw_i};
        d.win  = {q.win[FILT_LEN-2:0], q.sync[1]};
        ones   = '0;
        for (int i = 0; i < FILT_LEN; i++) begin
            ones = ones + CW'(q.win[i]);
        end
        d.lvl = (ones > CW'(FILT_LEN / 2));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sync <= {2{RST_VAL}};
            q.win  <= {FILT_LEN{RST_VAL}};
            q.lvl  <= RST_VAL;
        end else begin
            q <= d;
        end
    end

    assign line_o = q.lvl;

    // R12: the filtered level can only flip toward the newest sample
    assert_flip_follows_sample_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.lvl) |-> (q.lvl == $past(q.win[0])));
endmodule

// File: rtl/twp_cond_detect.sv
module twp_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f_i,
    input  logic sda_f_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t q, d;

    always_comb begin
        d.scl = scl_f_i;
        d.sda = sda_f_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign scl_rise_o = scl_f_i & ~q.scl;
    assign scl_fall_o = ~scl_f_i & q.scl;
    assign start_o    = scl_f_i & q.scl & q.sda & ~sda_f_i;
    assign stop_o     = scl_f_i & q.scl & ~q.sda & sda_f_i;
endmodule

// File: rtl/twp_byte_engine.sv
module twp_byte_engine
    import twp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int TYPE_W = 4,
    parameter logic [TYPE_W-1:0] TYPE_ID = 4'b0101,
    localparam int PIN_W = DATA_W - TYPE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl_i,
    input  logic              sda_lvl_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [PIN_W-1:0]  pin_addr_i,
    input  logic              nv_busy_i,
    input  logic              rd_mode_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              sda_oe_o,
    output logic              cmd_valid_o,
    output logic              wr_valid_o,
    output logic [DATA_W-1:0] rx_byte_o,
    output logic              xfer_end_o
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] FULL     = CNT_W'(DATA_W);

    typedef struct packed {
        twp_state_e        st;
        twp_kind_e         kind;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sh;
        logic              oe;
        logic              sel;
        logic              mack;
        logic              cmd_v;
        logic              wr_v;
        logic              end_v;
        logic [DATA_W-1:0] out_byte;
    } eng_t;

    eng_t q, d;
    logic [DATA_W-1:0] new_byte;
    logic              addr_hit;

    always_comb begin
        new_byte = {q.sh[DATA_W-2:0], sda_lvl_i};
        addr_hit = (new_byte[DATA_W-1:PIN_W] == TYPE_ID) &&
                   (new_byte[PIN_W-1:0] == pin_addr_i) && !nv_busy_i;

        d       = q;
        d.cmd_v = 1'b0;
        d.wr_v  = 1'b0;
        d.end_v = 1'b0;

        if (start_i) begin
            d.st   = ST_RX;
            d.kind = K_ADDR;
            d.cnt  = '0;
            d.oe   = 1'b0;
            d.sel  = 1'b0;
        end else if (stop_i) begin
            d.st    = ST_IDLE;
            d.oe    = 1'b0;
            d.sel   = 1'b0;
            d.end_v = q.sel;
        end else begin
            unique case (q.st)
                ST_IDLE: ;
                ST_RX: begin
                    if (scl_rise_i && q.cnt != FULL) begin
                        d.sh  = new_byte;
                        d.cnt = q.cnt + 1'b1;
                        if (q.cnt == LAST_BIT) begin
                            unique case (q.kind)
                                K_ADDR: d.sel = addr_hit;
                                K_CMD: begin
                                    d.cmd_v    = 1'b1;
                                    d.out_byte = new_byte;
                                end
                                default: begin
                                    d.wr_v     = 1'b1;
                                    d.out_byte = new_byte;
                                end
                            endcase
                        end
                    end else if (scl_fall_i && q.cnt == FULL) begin
                        if (q.sel) begin
                            d.oe = 1'b1;
                            d.st = ST_ACK;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall_i) begin
                        d.cnt = '0;
                        d.oe  = 1'b0;
                        unique case (q.kind)
                            K_ADDR: begin
                                d.st   = ST_RX;
                                d.kind = K_CMD;
                            end
                            K_CMD: begin
                                d.kind = K_DATA;
                                if (rd_mode_i) begin
                                    d.st = ST_TX;
                                    d.sh = rd_data_i;
                                    d.oe = ~rd_data_i[DATA_W-1];
                                end else begin
                                    d.st = ST_RX;
                                end
                            end
                            default: d.st = ST_RX;
                        endcase
                    end
                end
                ST_TX: begin
                    if (scl_rise_i) begin
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall_i) begin
                        if (q.cnt == FULL) begin
                            d.oe = 1'b0;
                            d.st = ST_MACK;
                        end else begin
                            d.sh = {q.sh[DATA_W-2:0], 1'b0};
                            d.oe = ~q.sh[DATA_W-2];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise_i) begin
                        d.mack = ~sda_lvl_i;
                    end else if (scl_fall_i) begin
                        d.cnt = '0;
                        if (q.mack) begin
                            d.st = ST_TX;
                            d.sh = rd_data_i;
                            d.oe = ~rd_data_i[DATA_W-1];
                        end else begin
                            d.st = ST_IDLE;
                            d.oe = 1'b0;
                        end
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st       <= ST_IDLE;
            q.kind     <= K_ADDR;
            q.cnt      <= '0;
            q.sh       <= '0;
            q.oe       <= 1'b0;
            q.sel      <= 1'b0;
            q.mack     <= 1'b0;
            q.cmd_v    <= 1'b0;
            q.wr_v     <= 1'b0;
            q.end_v    <= 1'b0;
            q.out_byte <= '0;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o    = q.oe;
    assign cmd_valid_o = q.cmd_v;
    assign wr_valid_o  = q.wr_v;
    assign rx_byte_o   = q.out_byte;
    assign xfer_end_o  = q.end_v;

    // R2: the pull-low enable moves only while the filtered clock is low
    assert_oe_moves_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.oe) |-> !$past(scl_lvl_i));

    // R1: an idle engine never holds the line
    assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> !q.oe);

    // R5: a busy address byte never selects the device
    assert_busy_no_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RX && q.kind == K_ADDR && q.cnt == FULL &&
         $past(q.cnt) == LAST_BIT && $past(nv_busy_i)) |-> !q.sel);

    // R6: a command pulse only follows an acknowledged address
    assert_cmd_needs_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q.cmd_v |-> q.sel);

    // R8: read data stays put across a clock rise
    assert_tx_hold_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_TX && scl_rise_i && !start_i && !stop_i) |=> $stable(q.oe));

    // R11: handoff pulses never coincide
    assert_one_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({q.cmd_v, q.wr_v, q.end_v}));
endmodule

// File: rtl/twp_slave_top.sv
module twp_slave_top #(
    parameter int DATA_W   = 8,
    parameter int TYPE_W   = 4,
    parameter logic [TYPE_W-1:0] TYPE_ID = 4'b0101,
    parameter int FILT_LEN = 3,
    localparam int PIN_W   = DATA_W - TYPE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [PIN_W-1:0]  pin_addr_i,
    input  logic              nv_busy_i,
    input  logic              rd_mode_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              cmd_valid_o,
    output logic              wr_valid_o,
    output logic [DATA_W-1:0] rx_byte_o,
    output logic              xfer_end_o
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] filt_lines;
    logic scl_rise, scl_fall, bus_start, bus_stop;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        twp_line_filter #(
            .FILT_LEN (FILT_LEN),
            .RST_VAL  (1'b1)
        ) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_lines[g]),
            .line_o (filt_lines[g])
        );
    end

    twp_cond_detect u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_f_i    (filt_lines[0]),
        .sda_f_i    (filt_lines[1]),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (bus_start),
        .stop_o     (bus_stop)
    );

    twp_byte_engine #(
        .DATA_W  (DATA_W),
        .TYPE_W  (TYPE_W),
        .TYPE_ID (TYPE_ID)
    ) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_lvl_i   (filt_lines[0]),
        .sda_lvl_i   (filt_lines[1]),
        .scl_rise_i  (scl_rise),
        .scl_fall_i  (scl_fall),
        .start_i     (bus_start),
        .stop_i      (bus_stop),
        .pin_addr_i  (pin_addr_i),
        .nv_busy_i   (nv_busy_i),
        .rd_mode_i   (rd_mode_i),
        .rd_data_i   (rd_data_i),
        .sda_oe_o    (sda_oe_o),
        .cmd_valid_o (cmd_valid_o),
        .wr_valid_o  (wr_valid_o),
        .rx_byte_o   (rx_byte_o),
        .xfer_end_o  (xfer_end_o)
    );
endmodule

// File: tb/twp_slave_top_test.sv
`timescale 1ns/1ps
module twp_slave_top_test;
    localparam int Q = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic [3:0] pins = 4'hA;
    logic       busy = 1'b0;
    logic       rd_mode = 1'b0;
    logic [7:0] rd_data = 8'h00;
    logic       cmd_v, wr_v, end_v;
    logic [7:0] rx_byte;

    int total = 0;
    int bad = 0;
    int cmd_cnt = 0, wr_cnt = 0, end_cnt = 0, oe_viol = 0;
    logic [7:0] last_cmd = 8'h00, last_wr = 8'h00;
    logic oe_prev = 1'b0;

    always #4 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;

    twp_slave_top uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (m_scl),
        .sda_i       (sda_line),
        .sda_oe_o    (sda_oe),
        .pin_addr_i  (pins),
        .nv_busy_i   (busy),
        .rd_mode_i   (rd_mode),
        .rd_data_i   (rd_data),
        .cmd_valid_o (cmd_v),
        .wr_valid_o  (wr_v),
        .rx_byte_o   (rx_byte),
        .xfer_end_o  (end_v)
    );

    always @(posedge clk) begin
        if (cmd_v) begin cmd_cnt <= cmd_cnt + 1; last_cmd <= rx_byte; end
        if (wr_v)  begin wr_cnt  <= wr_cnt + 1;  last_wr  <= rx_byte; end
        if (end_v) end_cnt <= end_cnt + 1;
    end

    // R2 monitor: the pull-low enable must not move while the raw clock is high
    always @(negedge clk) begin
        if (sda_oe !== oe_prev && m_scl) oe_viol = oe_viol + 1;
        oe_prev = sda_oe;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; half();
        m_scl = 1'b1; half();
        m_sda = 1'b0; half();
        m_scl = 1'b0; half();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; half();
        m_scl = 1'b1; half();
        m_sda = 1'b1; half();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n, input bit glitch);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i];
            if (glitch && i == 4) begin
                repeat (4) @(negedge clk);
                m_scl = 1'b1;
                @(negedge clk);
                m_scl = 1'b0;
                repeat (Q - 5) @(negedge clk);
            end else begin
                half();
            end
            m_scl = 1'b1; half(); half();
            m_scl = 1'b0; half();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
        send_bits(b, 8, glitch);
        m_sda = 1'b1; half();
        m_scl = 1'b1; half();
        ack = ~sda_line;
        half();
        m_scl = 1'b0; half();
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            half();
            m_scl = 1'b1; half();
            b[i] = sda_line;
            half();
            m_scl = 1'b0;
        end
        m_sda = ~mack; half();
        m_scl = 1'b1; half(); half();
        m_scl = 1'b0; half();
        m_sda = 1'b1;
    endtask

    task automatic t_reset();
        chk("R1 reset oe", sda_oe, 0);
        chk("R1 reset cmd pulse", cmd_v, 0);
        chk("R11 reset end pulse", end_v, 0);
    endtask

    task automatic t_no_start();
        bit a;
        send_byte(8'h5A, 0, a);
        chk("R1 no ack before start", a, 0);
        send_byte(8'h33, 0, a);
        chk("R1 no cmd before start", cmd_cnt, 0);
    endtask

    task automatic t_write();
        bit a;
        int c0 = cmd_cnt, w0 = wr_cnt, e0 = end_cnt;
        bus_start();
        send_byte(8'h5A, 0, a);  chk("R3 address ack", a, 1);
        send_byte(8'hC6, 0, a);  chk("R6 command ack", a, 1);
        chk("R6 cmd pulse", cmd_cnt - c0, 1);
        chk("R6 cmd byte", last_cmd, 8'hC6);
        send_byte(8'h2D, 0, a);  chk("R7 data ack", a, 1);
        chk("R7 data byte", last_wr, 8'h2D);
        send_byte(8'hF0, 0, a);  chk("R7 second data ack", a, 1);
        chk("R7 second data byte", last_wr, 8'hF0);
        chk("R7 data count", wr_cnt - w0, 2);
        bus_stop(); half();
        chk("R11 end pulse", end_cnt - e0, 1);
    endtask

    task automatic t_mismatch();
        bit a;
        int c0 = cmd_cnt, e0 = end_cnt;
        bus_start();
        send_byte(8'h5B, 0, a);  chk("R4 pin mismatch nack", a, 0);
        send_byte(8'h40, 0, a);  chk("R4 later byte ignored", a, 0);
        bus_start();
        send_byte(8'h7A, 0, a);  chk("R3 type mismatch nack", a, 0);
        bus_stop(); half();
        chk("R4 no cmd after mismatch", cmd_cnt - c0, 0);
        chk("R11 no end for unaddressed", end_cnt - e0, 0);
    endtask

    task automatic t_busy_poll();
        bit a;
        int e0 = end_cnt;
        busy = 1'b1;
        bus_start();
        send_byte(8'h5A, 0, a);  chk("R5 busy nack", a, 0);
        bus_stop();
        busy = 1'b0;
        bus_start();
        send_byte(8'h5A, 0, a);  chk("R5 ack after busy", a, 1);
        send_byte(8'h81, 0, a);
        bus_stop(); half();
        chk("R5 last cmd", last_cmd, 8'h81);
        chk("R11 end after poll", end_cnt - e0, 1);
    endtask

    task automatic t_read();
        bit a;
        logic [7:0] b;
        rd_mode = 1'b1;
        rd_data = 8'hA5;
        bus_start();
        send_byte(8'h5A, 0, a);
        send_byte(8'h90, 0, a);  chk("R8 read cmd ack", a, 1);
        rd_data = 8'h3C;
        recv_byte(1'b1, b);      chk("R8 first read byte", b, 8'hA5);
        recv_byte(1'b0, b);      chk("R9 reloaded read byte", b, 8'h3C);
        send_byte(8'h5A, 0, a);  chk("R9 ignored after master nack", a, 0);
        bus_stop(); half();
        rd_mode = 1'b0;
    endtask

    task automatic t_restart();
        bit a;
        int c0 = cmd_cnt;
        bus_start();
        send_bits(8'h5A, 4, 0);
        bus_start();
        send_byte(8'h5A, 0, a);  chk("R10 address after restart", a, 1);
        send_byte(8'h17, 0, a);
        chk("R10 cmd byte after restart", last_cmd, 8'h17);
        chk("R10 cmd count", cmd_cnt - c0, 1);
        bus_stop(); half();
    endtask

    task automatic t_glitch();
        bit a;
        bus_start();
        send_byte(8'h5A, 0, a);
        send_byte(8'h6E, 1, a);  chk("R12 ack with glitch", a, 1);
        chk("R12 byte with glitch", last_cmd, 8'h6E);
        bus_stop(); half();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_no_start();
        t_write();
        t_mismatch();
        t_busy_poll();
        t_read();
        t_restart();
        t_glitch();
        chk("R2 oe moved with clock high", oe_viol, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule